// File: doc/BRIEF.md
# Triggered Layer-1 Trace Capture Buffer

This block sits on a passive copy of a 40G media-independent stream: 128 data bits and 16 control bits each clock. Nothing flows back into the main data path. Once software or a controller pulses the arm strobe, every cycle of the stream is written into a circular on-chip buffer. That includes idle words, so the gaps between frames stay visible down to the byte. The write position wraps freely, so the buffer always holds the most recent stretch of traffic.

A trigger input comes from external detection logic, such as a frame check failure or a control code error. The block acts on it only while it is waiting. On that cycle it notes where the triggering word was stored and loads a post-trigger count. It keeps recording for that many further cycles, which gives error flags that arrive late time to land inside the window. Then it freezes. The frozen buffer holds context from before and after the event. A read port addressed relative to the oldest surviving word reads it out in time order.

A new arm strobe discards the previous capture and starts again, in any state.

Top module: `tcap_trace_buf`

## Requirements
- R1: After reset, `armed_o`, `triggered_o`, `done_o` and `rd_valid_o` are 0 and `fill_o` is 0.
- R2: Arming and recording:
  - One clock after an arm strobe, `armed_o` is 1.
  - The stream word on the arm cycle itself is not stored.
  - Every later cycle, idle words included, is stored in order, one word per clock.
- R3: A trigger is ignored when the block is not waiting for one, that is before any arm or after done. `triggered_o`, `done_o`, `fill_o` and the stored words are then unchanged.
- R4: A trigger seen while waiting is handled as follows:
  - The word of that cycle is stored.
  - `triggered_o` is 1 from the next clock on.
  - Exactly P further cycles are stored, where P is `post_cnt_i` sampled on the trigger cycle.
  - `done_o` rises on the clock that stores the last of them.
  - With P = 0, `done_o` rises on the clock that stores the trigger word.
- R5: Once `done_o` is 1, writes stop. `fill_o` and the buffer contents hold until the next arm.
- R6: Read index 0 is the oldest stored word and indexes ascend in time:
  - Before the write position wraps, index 0 is the first word after the arm and `fill_o` is the number of stored words.
  - After it wraps, `fill_o` equals the depth (64 by default) and index 0 is the word stored depth cycles before the end of capture.
- R7: `trig_idx_o` gives the read index of the trigger word once `done_o` is 1.
- R8: Read port:
  - A read request while `done_o` is 1 returns `rd_valid_o` = 1 with that word on the next clock.
  - Otherwise `rd_valid_o` is 0 and the read data is zero.
- R9: An arm strobe in any state, including during post-trigger recording, restarts capture. One clock later `done_o`, `triggered_o`, `fill_o` and `trig_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm strobe, restarts capture |
| trig_i | input | 1 | Trigger event from external detection |
| post_cnt_i | input | 16 | Cycles to record after the trigger |
| in_data_i | input | 128 | Tapped stream data |
| in_ctrl_i | input | 16 | Tapped stream control flags, one per byte |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 6 | Read index relative to oldest word |
| armed_o | output | 1 | Waiting for a trigger |
| triggered_o | output | 1 | Trigger accepted (post recording or done) |
| done_o | output | 1 | Capture frozen, buffer readable |
| fill_o | output | 7 | Number of valid stored words |
| trig_idx_o | output | 6 | Read index of the trigger word |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 128 | Read data |
| rd_ctrl_o | output | 16 | Read control flags |

## Verification
The assertions assume that `post_cnt_i` is held stable around the trigger cycle. They also assume that read requests arrive only when the stored content is meant to be looked at. Unwritten locations carry no reset value.

The stimulus changes `post_cnt_i` only before a scenario arms, and keeps it below the buffer depth, so the trigger word always survives in the frozen buffer. It reads only indexes below `fill_o`. All inputs change on the falling edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int LANE_BYTES = 16;
    localparam int DATA_W     = LANE_BYTES * 8;
    localparam int CTRL_W     = LANE_BYTES;
    localparam int WORD_W     = DATA_W + CTRL_W;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } l1_word_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_POST   = 2'd2,
        ST_FROZEN = 2'd3
    } cap_state_e;

    function automatic logic is_recording(cap_state_e s);
        return (s == ST_WAIT) || (s == ST_POST);
    endfunction

endpackage

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             trig,
    input  logic [CNT_W-1:0] post_cnt,
    output cap_state_e       state_o,
    output logic             wr_en_o,
    output logic             trig_hit_o
);

    cap_state_e       state_q;
    logic [CNT_W-1:0] left_q;

    always_comb begin
        wr_en_o    = is_recording(state_q) && !arm;
        trig_hit_o = (state_q == ST_WAIT) && trig && !arm;
        state_o    = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else if (arm) begin
            state_q <= ST_WAIT;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (trig) begin
                        if (post_cnt == '0) begin
                            state_q <= ST_FROZEN;
                        end else begin
                            state_q <= ST_POST;
                            left_q  <= post_cnt;
                        end
                    end
                end
                ST_POST: begin
                    if (left_q == CNT_W'(1)) begin
                        state_q <= ST_FROZEN;
                        left_q  <= '0;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: a trigger before any arm leaves the block idle
    p_idle_trig_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !arm) |=> (state_q == ST_IDLE));

    // R5: frozen capture holds until re-armed
    p_frozen_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FROZEN && !arm) |=> (state_q == ST_FROZEN));

    // R4: an accepted trigger leads to post recording or straight to frozen
    p_trig_accept_r4: assert property (@(posedge clk) disable iff (rst)
        trig_hit_o |=> (state_q == ST_POST || state_q == ST_FROZEN));

    // R4: post phase never runs with an exhausted counter
    p_post_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POST) |-> (left_q != '0));

endmodule

// File: rtl/tcap_wptr.sv
module tcap_wptr #(
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic          trig_hit,
    output logic [AW-1:0] ptr_o,
    output logic [AW-1:0] oldest_o,
    output logic [AW:0]   fill_o,
    output logic [AW-1:0] trig_rel_o
);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] trig_addr_q;
    logic          wrapped_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr_q       <= '0;
            trig_addr_q <= '0;
            wrapped_q   <= 1'b0;
        end else if (we) begin
            ptr_q <= ptr_q + 1'b1;
            if (ptr_q == {AW{1'b1}}) begin
                wrapped_q <= 1'b1;
            end
            if (trig_hit) begin
                trig_addr_q <= ptr_q;
            end
        end
    end

    always_comb begin
        ptr_o      = ptr_q;
        oldest_o   = wrapped_q ? ptr_q : '0;
        fill_o     = wrapped_q ? (AW+1)'(DEPTH) : {1'b0, ptr_q};
        trig_rel_o = trig_addr_q - oldest_o;
    end

    // R2: each stored word advances the write position by one
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (we && !clr) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));

    // R6: valid word count never exceeds the depth
    p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
        fill_o <= (AW+1)'(DEPTH));

    // R5: without a write and without clear, the pointer stands still
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!we && !clr) |=> $stable(ptr_q));

endmodule

// File: rtl/tcap_mem.sv
module tcap_mem #(
    parameter int AW = 6,
    parameter int W  = 144,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata_o,
    output logic          rvalid_o
);

    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= re;
            rdata_o  <= re ? store_q[raddr] : '0;
        end
    end

    // R8: no read request means no valid flag on the next clock
    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !re |=> !rvalid_o);

endmodule

// File: rtl/tcap_trace_buf.sv
module tcap_trace_buf
    import tcap_pkg::*;
#(
    parameter int AW    = 6,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              trig_i,
    input  logic [CNT_W-1:0]  post_cnt_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic [CTRL_W-1:0] in_ctrl_i,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic              armed_o,
    output logic              triggered_o,
    output logic              done_o,
    output logic [AW:0]       fill_o,
    output logic [AW-1:0]     trig_idx_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CTRL_W-1:0] rd_ctrl_o
);

    cap_state_e    state;
    logic          wr_en;
    logic          trig_hit;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] oldest;
    logic [AW-1:0] rd_phys;
    logic          rd_go;
    l1_word_t      wr_word;
    l1_word_t      rd_word;

    tcap_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm_i),
        .trig       (trig_i),
        .post_cnt   (post_cnt_i),
        .state_o    (state),
        .wr_en_o    (wr_en),
        .trig_hit_o (trig_hit)
    );

    tcap_wptr #(.AW(AW)) u_wptr (
        .clk        (clk),
        .rst        (rst),
        .clr        (arm_i),
        .we         (wr_en),
        .trig_hit   (trig_hit),
        .ptr_o      (wr_ptr),
        .oldest_o   (oldest),
        .fill_o     (fill_o),
        .trig_rel_o (trig_idx_o)
    );

    always_comb begin
        wr_word.ctrl = in_ctrl_i;
        wr_word.data = in_data_i;
        rd_go        = rd_en_i && (state == ST_FROZEN);
        rd_phys      = oldest + rd_addr_i;
        armed_o      = (state == ST_WAIT);
        triggered_o  = (state == ST_POST) || (state == ST_FROZEN);
        done_o       = (state == ST_FROZEN);
        rd_data_o    = rd_word.data;
        rd_ctrl_o    = rd_word.ctrl;
    end

    tcap_mem #(.AW(AW), .W(WORD_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .waddr    (wr_ptr),
        .wdata    (wr_word),
        .re       (rd_go),
        .raddr    (rd_phys),
        .rdata_o  (rd_word),
        .rvalid_o (rd_valid_o)
    );

    // R1: status and read port come out of reset quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!armed_o && !triggered_o && !done_o && !rd_valid_o && fill_o == '0));

    // R9: an arm strobe clears all capture state on the next clock
    p_arm_clears_r9: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (armed_o && !done_o && !triggered_o && fill_o == '0 && trig_idx_o == '0));

    // R8: reads are refused unless the capture is frozen
    p_rd_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (!done_o || !rd_en_i) |=> (!rd_valid_o && rd_data_o == '0));

    // R5: frozen buffer keeps its fill level
    p_frozen_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> $stable(fill_o));

    // R3: a trigger when not waiting does not start post recording
    p_late_trig_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (!armed_o && !triggered_o && !arm_i) |=> !triggered_o);

endmodule

// File: tb/test_tcap_trace_buf.sv
`timescale 1ns/1ps
module test_tcap_trace_buf;

    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          arm_i, trig_i, rd_en_i;
    logic [15:0]   post_cnt_i;
    logic [127:0]  in_data_i;
    logic [15:0]   in_ctrl_i;
    logic [AW-1:0] rd_addr_i;
    logic          armed_o, triggered_o, done_o, rd_valid_o;
    logic [AW:0]   fill_o;
    logic [AW-1:0] trig_idx_o;
    logic [127:0]  rd_data_o;
    logic [15:0]   rd_ctrl_o;

    int unsigned seq = 100;
    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tcap_trace_buf i_tcap_trace_buf (
        .clk(clk), .rst(rst), .arm_i(arm_i), .trig_i(trig_i), .post_cnt_i(post_cnt_i),
        .in_data_i(in_data_i), .in_ctrl_i(in_ctrl_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .armed_o(armed_o), .triggered_o(triggered_o), .done_o(done_o), .fill_o(fill_o),
        .trig_idx_o(trig_idx_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ctrl_o(rd_ctrl_o)
    );

    function automatic logic [143:0] pat(int unsigned s);
        logic [15:0] c;
        if (s % 5 == 0) return {16'hFFFF, {16{8'h07}}};
        c = s[15:0] ^ 16'h00F0;
        return {c, s, ~s, s ^ 32'h5A5AA5A5, s * 32'd3};
    endfunction

    task automatic check(string tag, logic [143:0] act, logic [143:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one stream cycle at a falling edge, return at the next falling edge
    task automatic cyc(bit a, bit t);
        arm_i  = a;
        trig_i = t;
        {in_ctrl_i, in_data_i} = pat(seq);
        seq++;
        @(negedge clk);
        arm_i  = 1'b0;
        trig_i = 1'b0;
    endtask

    task automatic rd(int idx, output logic v, output logic [143:0] w);
        rd_en_i   = 1'b1;
        rd_addr_i = AW'(idx);
        @(negedge clk);
        v = rd_valid_o;
        w = {rd_ctrl_o, rd_data_o};
        rd_en_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 armed", armed_o, 0);
        check("R1 triggered", triggered_o, 0);
        check("R1 done", done_o, 0);
        check("R1 rd_valid", rd_valid_o, 0);
        check("R1 fill", fill_o, 0);
    endtask

    task automatic t_unarmed;
        logic v; logic [143:0] w;
        for (int i = 0; i < 4; i++) cyc(0, 1);
        check("R3 idle trig triggered", triggered_o, 0);
        check("R3 idle trig done", done_o, 0);
        check("R3 idle trig fill", fill_o, 0);
        rd(0, v, w);
        check("R8 read before done valid", v, 0);
        check("R8 read before done data", w, 0);
    endtask

    task automatic t_basic;
        int unsigned first;
        logic v; logic [143:0] w;
        post_cnt_i = 16'd4;
        cyc(1, 0);
        check("R2 armed after strobe", armed_o, 1);
        check("R2 fill after strobe", fill_o, 0);
        first = seq;
        for (int i = 0; i < 10; i++) cyc(0, 0);
        check("R2 fill counts cycles", fill_o, 10);
        cyc(0, 1);
        check("R4 triggered next clock", triggered_o, 1);
        check("R4 armed drops", armed_o, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0);
        check("R4 not done before P words", done_o, 0);
        cyc(0, 0);
        check("R4 done after P words", done_o, 1);
        check("R4 fill", fill_o, 15);
        check("R7 trig index", trig_idx_o, 10);
        for (int i = 0; i < 15; i++) begin
            rd(i, v, w);
            check("R8 valid", v, 1);
            check($sformatf("R6 word %0d", i), w, pat(first + i));
        end
        for (int i = 0; i < 5; i++) cyc(0, 1);
        check("R5 fill frozen", fill_o, 15);
        check("R3 late trig keeps done", done_o, 1);
        rd(14, v, w);
        check("R5 last word kept", w, pat(first + 14));
        rd(10, v, w);
        check("R7 trigger word", w, pat(first + 10));
    endtask

    task automatic t_zero_post;
        int unsigned first;
        logic v; logic [143:0] w;
        post_cnt_i = 16'd0;
        cyc(1, 0);
        check("R9 done cleared", done_o, 0);
        check("R9 triggered cleared", triggered_o, 0);
        check("R9 fill cleared", fill_o, 0);
        check("R9 trig index cleared", trig_idx_o, 0);
        first = seq;
        for (int i = 0; i < 3; i++) cyc(0, 0);
        cyc(0, 1);
        check("R4 P=0 done at once", done_o, 1);
        check("R4 P=0 fill", fill_o, 4);
        check("R7 P=0 index", trig_idx_o, 3);
        rd(3, v, w);
        check("R4 P=0 last is trigger word", w, pat(first + 3));
    endtask

    task automatic t_wrap;
        int unsigned first, oldest;
        logic v; logic [143:0] w;
        post_cnt_i = 16'd5;
        cyc(1, 0);
        first = seq;
        for (int i = 0; i < 99; i++) cyc(0, 0);
        cyc(0, 1);
        for (int i = 0; i < 5; i++) cyc(0, 0);
        check("R4 wrap done", done_o, 1);
        check("R6 wrap fill", fill_o, DEPTH);
        oldest = first + 105 - DEPTH;
        check("R7 wrap trig index", trig_idx_o, 99 - (105 - DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, v, w);
            check($sformatf("R6 wrapped word %0d", i), w, pat(oldest + i));
        end
    endtask

    task automatic t_rearm_post;
        int unsigned first;
        logic v; logic [143:0] w;
        post_cnt_i = 16'd10;
        cyc(1, 0);
        cyc(0, 0);
        cyc(0, 1);
        cyc(0, 0);
        check("R9 in post before rearm", triggered_o, 1);
        post_cnt_i = 16'd1;
        cyc(1, 0);
        check("R9 rearm in post armed", armed_o, 1);
        check("R9 rearm in post triggered", triggered_o, 0);
        check("R9 rearm in post fill", fill_o, 0);
        first = seq;
        cyc(0, 0);
        cyc(0, 0);
        cyc(0, 1);
        cyc(0, 0);
        check("R9 restarted capture done", done_o, 1);
        check("R9 restarted fill", fill_o, 4);
        check("R7 restarted index", trig_idx_o, 2);
        rd(0, v, w);
        check("R9 first word after rearm", w, pat(first));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; arm_i = 0; trig_i = 0; rd_en_i = 0; rd_addr_i = '0;
        post_cnt_i = '0; in_data_i = '0; in_ctrl_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unarmed();
        t_basic();
        t_zero_post();
        t_wrap();
        t_rearm_post();
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule